// File: doc/BRIEF.md
# Cluster Register File with Remote Write Synchronisation

This block is the integer register file of one processor cluster in a three-cluster node. Besides the cluster's own pipeline, the two peer clusters can write straight into its registers by sending a transfer over the shared inter-cluster switch. Every register carries a presence flag. A remote arrival marks the register full. A consuming instruction marks it empty again. An instruction that reads an empty register is held back by a stall signal until the awaited value lands. A producer in another cluster and a consumer here can therefore hand values over with no memory traffic.

Incoming switch traffic passes through a one-entry input stage. Only one transfer can be taken per cycle. A staged transfer may write only into an empty register, and only when the local pipeline is not writing that same register in that cycle. While the staged transfer is waiting, the block drops its ready signal to the switch. Because of the input stage, a remote value becomes visible exactly one cycle later than a local write presented in the same cycle. Transfers that name an invalid sender or an invalid register are taken and thrown away.

Top module: `crf_cluster_regfile`

## Requirements
- R1: After synchronous reset, all 14 registers read zero, every presence flag is full (so no stall occurs), and `rx_ready` is high.
- R2: A local write with `lw_en` high to a register index 0 to 13 is visible on the read ports in the next cycle. It does not change that register's presence flag.
- R3: A transfer taken while `rx_valid` and `rx_ready` are both high, naming an empty register, is visible on the read ports two cycles later. This is one cycle more than a local write. The write also sets the register's presence flag.
- R4: At most one transfer is taken per cycle. While a staged transfer cannot be written, `rx_ready` is low and the staged transfer stays unchanged.
- R5: A staged transfer never overwrites a register whose presence flag is set. It waits, with `rx_ready` low, until a consume clears the flag, and is written in the cycle after the clear.
- R6: `cons_en` with `cons_reg` in 0 to 13 clears that register's presence flag at the next edge. A remote write landing on the same register in the same cycle keeps the flag set.
- R7: `stall` is high exactly when an operand with its use bit set (`rd_use_a` or `rd_use_b`) names a register whose presence flag is clear.
- R8: When the local write and the staged remote write target the same register in the same cycle, the local data is written and the remote write is held one cycle. The remote write then lands, so it is the value that remains.
- R9: A transfer whose sender id equals the block's own id (parameter `SELF_ID`, default 0), or is 3, or whose register index is 14 or 15, is taken and discarded. No register and no presence flag changes.
- R10: Local writes to index 14 or 15 are ignored. Reads of those indices return zero and never stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lw_en | input | 1 | Local pipeline write enable |
| lw_reg | input | 4 | Local write register index |
| lw_data | input | 66 | Local write data |
| rx_valid | input | 1 | Switch transfer offered |
| rx_src | input | 2 | Sending cluster id |
| rx_reg | input | 4 | Destination register index |
| rx_data | input | 66 | Transfer data |
| rx_ready | output | 1 | Block can take a transfer this cycle |
| rd_reg_a | input | 4 | Operand A register index |
| rd_use_a | input | 1 | Operand A is read by the issuing instruction |
| rd_reg_b | input | 4 | Operand B register index |
| rd_use_b | input | 1 | Operand B is read by the issuing instruction |
| rd_data_a | output | 66 | Operand A value |
| rd_data_b | output | 66 | Operand B value |
| stall | output | 1 | Issuing instruction reads an empty register |
| cons_en | input | 1 | Consumer marks a register empty |
| cons_reg | input | 4 | Register index to mark empty |

## Verification
A wrong presence flag shows at the ports in the same cycle it is read. It appears as a stall that should not occur, as a missing stall, or as `rx_ready` staying low while a staged transfer should land. A lost or misdirected data write shows on the read ports one cycle after a local write or two cycles after a remote acceptance. A staged transfer that is dropped or duplicated changes `rx_ready` in the following cycle. The bench compares every output against a behavioural model on every clock, so any of these faults is flagged within one to two cycles of its cause.

// File: rtl/crf_pkg.sv
package crf_pkg;

    localparam int NUM_CLUSTERS = 3;
    localparam int CID_W        = 2;
    localparam int NUM_REGS     = 14;
    localparam int REG_W        = 4;
    localparam int DATA_W       = 66;
    localparam int IDX_SPAN     = 1 << REG_W;

    typedef logic [REG_W-1:0]  reg_idx_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [CID_W-1:0]  cid_t;

    typedef struct packed {
        cid_t     src;
        reg_idx_t idx;
        word_t    data;
    } xfer_t;

    function automatic logic idx_valid(input reg_idx_t idx);
        return int'(idx) < NUM_REGS;
    endfunction

    function automatic logic src_valid(input cid_t src, input cid_t self_id);
        return (src != self_id) && (int'(src) < NUM_CLUSTERS);
    endfunction

endpackage

// File: rtl/crf_stage.sv
module crf_stage
    import crf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_load,
    input  xfer_t in_xfer,
    input  logic  commit,
    output logic  stg_valid,
    output xfer_t stg_xfer,
    output logic  ready
);

    assign ready = !stg_valid || commit;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_valid <= 1'b0;
            stg_xfer  <= '0;
        end else if (in_load && ready) begin
            stg_valid <= 1'b1;
            stg_xfer  <= in_xfer;
        end else if (commit) begin
            stg_valid <= 1'b0;
        end
    end

    // R4: a staged transfer that cannot land is held unchanged
    assert_stage_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (stg_valid && !commit) |=> (stg_valid && $stable(stg_xfer)));

    // R4: a commit only happens from a valid stage
    assert_commit_valid_R4: assert property (@(posedge clk) disable iff (rst)
        commit |-> stg_valid);

endmodule

// File: rtl/crf_presence.sv
module crf_presence
    import crf_pkg::*;
#(
    parameter int N_REGS = NUM_REGS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  reg_idx_t          set_idx,
    input  logic              clr_en,
    input  reg_idx_t          clr_idx,
    output logic [N_REGS-1:0] full
);

    localparam int PAD = IDX_SPAN - N_REGS;

    logic [IDX_SPAN-1:0] full_pad;
    assign full_pad = {{PAD{1'b1}}, full};

    genvar gi;
    generate
        for (gi = 0; gi < N_REGS; gi++) begin : g_flag
            always_ff @(posedge clk) begin
                if (rst) begin
                    full[gi] <= 1'b1;
                end else if (set_en && set_idx == REG_W'(gi)) begin
                    full[gi] <= 1'b1;
                end else if (clr_en && clr_idx == REG_W'(gi)) begin
                    full[gi] <= 1'b0;
                end
            end
        end
    endgenerate

    // R3: a landed remote write leaves the flag full
    assert_set_full_R3: assert property (@(posedge clk) disable iff (rst)
        set_en |=> full_pad[$past(set_idx)]);

    // R5: a landing write only targets an empty register
    assert_no_overwrite_R5: assert property (@(posedge clk) disable iff (rst)
        set_en |-> !full_pad[set_idx]);

    // R6: a consume without a colliding landing empties the flag
    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_en && idx_valid(clr_idx) && !(set_en && set_idx == clr_idx))
            |=> !full_pad[$past(clr_idx)]);

endmodule

// File: rtl/crf_array.sv
module crf_array
    import crf_pkg::*;
#(
    parameter int N_REGS = NUM_REGS
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     lw_en,
    input  reg_idx_t lw_idx,
    input  word_t    lw_data,
    input  logic     cm_en,
    input  reg_idx_t cm_idx,
    input  word_t    cm_data,
    input  reg_idx_t rd_idx_a,
    input  reg_idx_t rd_idx_b,
    output word_t    rd_a,
    output word_t    rd_b
);

    word_t mem [N_REGS];

    genvar gi;
    generate
        for (gi = 0; gi < N_REGS; gi++) begin : g_word
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem[gi] <= '0;
                end else if (lw_en && lw_idx == REG_W'(gi)) begin
                    mem[gi] <= lw_data;
                end else if (cm_en && cm_idx == REG_W'(gi)) begin
                    mem[gi] <= cm_data;
                end
            end

            // R2: a local write is stored at its index
            assert_local_store_R2: assert property (@(posedge clk) disable iff (rst)
                (lw_en && lw_idx == REG_W'(gi)) |=> (mem[gi] == $past(lw_data)));
        end
    endgenerate

    always_comb begin
        rd_a = '0;
        rd_b = '0;
        for (int i = 0; i < N_REGS; i++) begin
            if (rd_idx_a == REG_W'(i)) rd_a = mem[i];
            if (rd_idx_b == REG_W'(i)) rd_b = mem[i];
        end
    end

    // R8: the top never lets both writers hit one register in one cycle
    assert_no_collision_R8: assert property (@(posedge clk) disable iff (rst)
        !(lw_en && cm_en && lw_idx == cm_idx));

endmodule

// File: rtl/crf_cluster_regfile.sv
module crf_cluster_regfile
    import crf_pkg::*;
#(
    parameter int SELF_ID = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                lw_en,
    input  logic [REG_W-1:0]    lw_reg,
    input  logic [DATA_W-1:0]   lw_data,
    input  logic                rx_valid,
    input  logic [CID_W-1:0]    rx_src,
    input  logic [REG_W-1:0]    rx_reg,
    input  logic [DATA_W-1:0]   rx_data,
    output logic                rx_ready,
    input  logic [REG_W-1:0]    rd_reg_a,
    input  logic                rd_use_a,
    input  logic [REG_W-1:0]    rd_reg_b,
    input  logic                rd_use_b,
    output logic [DATA_W-1:0]   rd_data_a,
    output logic [DATA_W-1:0]   rd_data_b,
    output logic                stall,
    input  logic                cons_en,
    input  logic [REG_W-1:0]    cons_reg
);

    localparam cid_t SELF_CID = CID_W'(SELF_ID);
    localparam int   PAD      = IDX_SPAN - NUM_REGS;

    logic                lw_ok;
    logic                rx_good;
    logic                stg_valid;
    xfer_t               stg_xfer;
    xfer_t               in_xfer;
    logic                commit;
    logic [NUM_REGS-1:0] full;
    logic [IDX_SPAN-1:0] full_pad;

    assign lw_ok    = lw_en && idx_valid(lw_reg);
    assign rx_good  = rx_valid && src_valid(rx_src, SELF_CID) && idx_valid(rx_reg);
    assign in_xfer  = '{src: rx_src, idx: rx_reg, data: rx_data};
    assign full_pad = {{PAD{1'b1}}, full};

    assign commit = stg_valid && !full_pad[stg_xfer.idx]
                    && !(lw_ok && lw_reg == stg_xfer.idx);

    crf_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_load   (rx_good),
        .in_xfer   (in_xfer),
        .commit    (commit),
        .stg_valid (stg_valid),
        .stg_xfer  (stg_xfer),
        .ready     (rx_ready)
    );

    crf_presence #(.N_REGS(NUM_REGS)) u_presence (
        .clk     (clk),
        .rst     (rst),
        .set_en  (commit),
        .set_idx (stg_xfer.idx),
        .clr_en  (cons_en),
        .clr_idx (cons_reg),
        .full    (full)
    );

    crf_array #(.N_REGS(NUM_REGS)) u_array (
        .clk      (clk),
        .rst      (rst),
        .lw_en    (lw_ok),
        .lw_idx   (lw_reg),
        .lw_data  (lw_data),
        .cm_en    (commit),
        .cm_idx   (stg_xfer.idx),
        .cm_data  (stg_xfer.data),
        .rd_idx_a (rd_reg_a),
        .rd_idx_b (rd_reg_b),
        .rd_a     (rd_data_a),
        .rd_b     (rd_data_b)
    );

    assign stall = (rd_use_a && !full_pad[rd_reg_a]) || (rd_use_b && !full_pad[rd_reg_b]);

    // R4: backpressure only while a transfer is staged
    assert_ready_low_R4: assert property (@(posedge clk) disable iff (rst)
        !rx_ready |-> stg_valid);

    // R7: stall requires a used operand
    assert_stall_cause_R7: assert property (@(posedge clk) disable iff (rst)
        stall |-> (rd_use_a || rd_use_b));

    // R9: a rejected transfer never fills the stage
    assert_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_good && !stg_valid) |=> !stg_valid);

endmodule

// File: tb/sim_crf_cluster_regfile.sv
`timescale 1ns/1ps
module sim_crf_cluster_regfile;

    localparam int DW   = 66;
    localparam int NR   = 14;
    localparam int SELF = 0;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          lw_en = 1'b0;
    logic [3:0]    lw_reg = '0;
    logic [DW-1:0] lw_data = '0;
    logic          rx_valid = 1'b0;
    logic [1:0]    rx_src = '0;
    logic [3:0]    rx_reg = '0;
    logic [DW-1:0] rx_data = '0;
    logic          rx_ready;
    logic [3:0]    rd_reg_a = '0;
    logic          rd_use_a = 1'b0;
    logic [3:0]    rd_reg_b = '0;
    logic          rd_use_b = 1'b0;
    logic [DW-1:0] rd_data_a;
    logic [DW-1:0] rd_data_b;
    logic          stall;
    logic          cons_en = 1'b0;
    logic [3:0]    cons_reg = '0;

    always #2 clk = ~clk;

    crf_cluster_regfile #(.SELF_ID(SELF)) u0 (
        .clk(clk), .rst(rst),
        .lw_en(lw_en), .lw_reg(lw_reg), .lw_data(lw_data),
        .rx_valid(rx_valid), .rx_src(rx_src), .rx_reg(rx_reg), .rx_data(rx_data),
        .rx_ready(rx_ready),
        .rd_reg_a(rd_reg_a), .rd_use_a(rd_use_a), .rd_reg_b(rd_reg_b), .rd_use_b(rd_use_b),
        .rd_data_a(rd_data_a), .rd_data_b(rd_data_b), .stall(stall),
        .cons_en(cons_en), .cons_reg(cons_reg)
    );

    // behavioural reference: 16 slots, 14 and 15 stay zero and full
    logic [DW-1:0] m_mem  [16];
    logic          m_full [16];
    logic          m_sv;
    logic [3:0]    m_sa;
    logic [DW-1:0] m_sd;

    int n_checks = 0;
    int n_fail   = 0;

    task automatic model_reset();
        for (int i = 0; i < 16; i++) begin
            m_mem[i]  = '0;
            m_full[i] = 1'b1;
        end
        m_sv = 1'b0;
        m_sa = '0;
        m_sd = '0;
    endtask

    task automatic chk1(input string tag, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0b exp=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic chkw(input string tag, input string what, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // compare outputs for the current inputs, advance the model, move to next negedge
    task automatic step(input string tag);
        logic lw_ok, commit, ready, take, e_stall;
        #1;
        lw_ok   = lw_en && (lw_reg < NR);
        commit  = m_sv && !m_full[m_sa] && !(lw_ok && lw_reg == m_sa);
        ready   = !m_sv || commit;
        e_stall = (rd_use_a && !m_full[rd_reg_a]) || (rd_use_b && !m_full[rd_reg_b]);
        chk1(tag, "rx_ready", rx_ready, ready);
        chk1(tag, "stall", stall, e_stall);
        chkw(tag, "rd_data_a", rd_data_a, m_mem[rd_reg_a]);
        chkw(tag, "rd_data_b", rd_data_b, m_mem[rd_reg_b]);
        take = rx_valid && ready && (rx_src != 2'(SELF)) && (rx_src != 2'd3) && (rx_reg < NR);
        if (lw_ok) m_mem[lw_reg] = lw_data;
        if (cons_en && cons_reg < NR) m_full[cons_reg] = 1'b0;
        if (commit) begin
            m_mem[m_sa]  = m_sd;
            m_full[m_sa] = 1'b1;
            m_sv = 1'b0;
        end
        if (take) begin
            m_sv = 1'b1;
            m_sa = rx_reg;
            m_sd = rx_data;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        lw_en = 1'b0; rx_valid = 1'b0; cons_en = 1'b0;
        rd_use_a = 1'b0; rd_use_b = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [3:0] b);
        rd_reg_a = a; rd_use_a = 1'b1; rd_reg_b = b; rd_use_b = 1'b1;
    endtask

    function automatic logic [DW-1:0] rword();
        logic [95:0] t;
        t = {$urandom(), $urandom(), $urandom()};
        return t[DW-1:0];
    endfunction

    task automatic send(input logic [1:0] s, input logic [3:0] r, input logic [DW-1:0] d);
        rx_valid = 1'b1; rx_src = s; rx_reg = r; rx_data = d;
    endtask

    initial begin : watchdog
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset contents, flags and ready
        for (int r = 0; r < 16; r++) begin
            idle(); rd(4'(r), 4'(15 - r));
            step("R1");
        end

        // R2: local writes visible next cycle, flag unchanged
        idle(); lw_en = 1'b1; lw_reg = 4'd3; lw_data = 66'h2_1234_5678_9abc_def0; rd(4'd3, 4'd4);
        step("R2");
        lw_reg = 4'd4; lw_data = 66'h1_0f0f_0f0f_0f0f_0f0f;
        step("R2");
        idle(); rd(4'd3, 4'd4);
        step("R2");

        // R6 and R7: consume empties, read of empty stalls
        idle(); cons_en = 1'b1; cons_reg = 4'd5;
        step("R6");
        idle(); rd(4'd5, 4'd3);
        step("R7");
        rd_use_a = 1'b0;
        step("R7");

        // R3: remote write lands two cycles after acceptance
        idle(); rd(4'd5, 4'd0); send(2'd1, 4'd5, 66'h3_aaaa_bbbb_cccc_dddd);
        step("R3");
        rx_valid = 1'b0;
        step("R3");
        step("R3");

        // R5 and R4: write to a full register waits for a consume
        idle(); rd(4'd6, 4'd6); send(2'd2, 4'd6, 66'h0_5555_6666_7777_8888);
        step("R5");
        send(2'd1, 4'd8, 66'h1_1111_2222_3333_4444);
        step("R4");
        step("R4");
        rx_valid = 1'b0; cons_en = 1'b1; cons_reg = 4'd6;
        step("R5");
        cons_en = 1'b0;
        step("R5");
        step("R5");

        // R8: local and remote hit the same register in one cycle
        idle(); cons_en = 1'b1; cons_reg = 4'd7;
        step("R8");
        idle(); rd(4'd7, 4'd7); send(2'd2, 4'd7, 66'h2_dead_beef_0000_0001);
        step("R8");
        rx_valid = 1'b0; lw_en = 1'b1; lw_reg = 4'd7; lw_data = 66'h0_cafe_f00d_0000_0002;
        step("R8");
        lw_en = 1'b0;
        step("R8");
        step("R8");

        // R9: bad sender or bad index is taken and discarded
        idle(); cons_en = 1'b1; cons_reg = 4'd2;
        step("R9");
        idle(); rd(4'd2, 4'd14); send(2'(SELF), 4'd2, 66'h1_0000_0000_0000_0001);
        step("R9");
        send(2'd3, 4'd2, 66'h1_0000_0000_0000_0002);
        step("R9");
        send(2'd1, 4'd14, 66'h1_0000_0000_0000_0003);
        step("R9");
        send(2'd2, 4'd15, 66'h1_0000_0000_0000_0004);
        step("R9");
        rx_valid = 1'b0;
        step("R9");
        step("R9");
        send(2'd1, 4'd2, 66'h1_0000_0000_0000_0005);
        step("R9");
        rx_valid = 1'b0;
        step("R9");
        step("R9");

        // R10: local write outside the file is ignored
        idle(); lw_en = 1'b1; lw_reg = 4'd15; lw_data = 66'h3_ffff_ffff_ffff_ffff; rd(4'd15, 4'd14);
        step("R10");
        lw_en = 1'b0;
        step("R10");

        // R4 and R5 under mixed random traffic
        for (int k = 0; k < 4000; k++) begin
            lw_en    = ($urandom_range(0, 3) == 0);
            lw_reg   = 4'($urandom_range(0, 15));
            lw_data  = rword();
            rx_valid = ($urandom_range(0, 1) == 0);
            rx_src   = 2'($urandom_range(0, 3));
            rx_reg   = 4'($urandom_range(0, 15));
            rx_data  = rword();
            cons_en  = ($urandom_range(0, 2) == 0);
            cons_reg = 4'($urandom_range(0, 15));
            rd_reg_a = 4'($urandom_range(0, 15));
            rd_use_a = $urandom_range(0, 1) == 1;
            rd_reg_b = 4'($urandom_range(0, 15));
            rd_use_b = $urandom_range(0, 1) == 1;
            step("R4");
        end

        idle();
        step("R1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule